// File: doc/BRIEF.md
# Clock-synchronous serial transmitter

This block sends bytes over a clock-synchronous serial link and makes the shift clock itself. A byte written into a one-deep holding buffer moves into a shift register as soon as sending is allowed. It then leaves on the data line, lowest bit first, beside a clock output that idles high. The data line changes on each falling clock edge, so a receiver samples on the rising edge.

The bit period comes from a two-stage divider. A count source is chosen from the undivided clock, the clock divided by a fixed factor, or the clock divided by twice a prescale value. A baud value `m` then stretches each clock half-period to `m+1` count-source cycles. A character may begin only while sending is enabled and, when flow control is switched on, while the active-low clear-to-send input is low. The gate is tested only at character boundaries, so a character that has begun always finishes. Two status outputs show whether the buffer is free and whether the transmitter is idle. A one-cycle interrupt pulse marks either the buffer transfer or the end of a character.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset `buf_empty`=1, `tx_idle`=1, `sclk`=1, `txd`=1 and `irq`=0.
- R2: Each half-period of `sclk` lasts P*(m+1) clock cycles, with m=`baud_m`. P depends on `src_sel`: 0 gives P=1, 1 gives P=8, and 2 or 3 gives P=2*n with n=`pre_n` (n=0 is taken as 1).
- R3: Each character carries 8 bits, bit 0 first. `sclk` goes low when the character starts. `txd` changes only while `sclk` is low or the transmitter is idle. The value of `txd` at each rising edge of `sclk` is the next data bit.
- R4: A buffer write drives `buf_empty` to 0 one cycle later. The transfer into the shift register takes place on the next clock edge at which sending is allowed. That edge drives `buf_empty` to 1, `tx_idle` to 0 and `sclk` to 0.
- R5: If the buffer holds a byte at the end of a character and sending is allowed, the next character starts on that same edge. `sclk` then falls exactly one half-period after its last rise, and `tx_idle` stays 0.
- R6: While `cts_en`=1 and `cts_n`=1, no character starts and the byte stays in the buffer. The first edge that samples `cts_n`=0 starts it. While `cts_en`=0, `cts_n` has no effect.
- R7: While `tx_en`=0, no character starts. Clearing `tx_en` during a character lets that character finish. After it, `sclk` stays high and the buffered byte waits.
- R8: With `irq_sel`=0, `irq` pulses for one cycle right after each buffer transfer. With `irq_sel`=1, it pulses for one cycle right after the last half-period of each character.
- R9: `tx_idle` is 0 from the transfer edge until one half-period after the final rising edge of `sclk` in the last character of a burst. At that point `txd` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Count source: 0 undivided, 1 fixed /8, 2 or 3 divide by 2n |
| pre_n | input | 8 | Prescale value n for the divide-by-2n source |
| baud_m | input | 8 | Baud value m |
| tx_en | input | 1 | Allows new characters to start |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_sel | input | 1 | Interrupt source: 0 buffer transfer, 1 end of character |
| buf_wr | input | 1 | Write strobe for the holding buffer |
| buf_data | input | 8 | Byte to write |
| txd | output | 1 | Serial data |
| sclk | output | 1 | Shift clock, idles high |
| buf_empty | output | 1 | Holding buffer is free |
| tx_idle | output | 1 | No character in progress |
| irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
A wrong divider state shows up in the first half-period after a transfer, as an `sclk` edge early or late by whole count-source periods. Timing every half-period against P*(m+1) therefore catches it within one bit. A wrong half-period count or shift state shows within one character: as a wrong bit order, a seventeenth edge, or `tx_idle` returning early. A wrong buffer flag or start gate shows within one cycle of a write or of a change on `cts_n` or `tx_en`. It appears as `tx_idle` falling when it should not, or failing to fall.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

  typedef enum logic [1:0] {
    SRC_FULL  = 2'd0,
    SRC_SLOW  = 2'd1,
    SRC_PRE2N = 2'd2,
    SRC_ALT2N = 2'd3
  } src_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } tx_state_e;

  // clock cycles per count-source tick
  function automatic int unsigned src_period(input logic [1:0] sel,
                                             input int unsigned n,
                                             input int unsigned slow);
    case (src_e'(sel))
      SRC_FULL: return 1;
      SRC_SLOW: return slow;
      default:  return 2 * ((n == 0) ? 1 : n);
    endcase
  endfunction

  // clock cycles per shift-clock half period
  function automatic int unsigned half_period(input int unsigned src_cycles,
                                              input int unsigned m);
    return src_cycles * (m + 1);
  endfunction

endpackage

// File: rtl/sstx_clkgen.sv
module sstx_clkgen #(
  parameter int MW       = 8,
  parameter int NW       = 8,
  parameter int SLOW_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    src_sel,
  input  logic [NW-1:0] pre_n,
  input  logic [MW-1:0] baud_m,
  output logic          half_tick
);
  localparam int SW = $clog2(SLOW_DIV) + 1;
  localparam int PW = (NW + 1 > SW) ? NW + 1 : SW;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] plim;
  logic [MW-1:0] bcnt;
  logic          src_tick;

  always_comb begin
    plim = PW'(sstx_pkg::src_period(src_sel, 32'(pre_n), 32'(SLOW_DIV)) - 1);
  end

  assign src_tick  = run && (pcnt == plim);
  assign half_tick = src_tick && (bcnt == baud_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      bcnt <= '0;
    end else if (!run) begin
      pcnt <= '0;
      bcnt <= '0;
    end else begin
      pcnt <= src_tick ? '0 : pcnt + 1'b1;
      if (src_tick) bcnt <= (bcnt == baud_m) ? '0 : bcnt + 1'b1;
    end
  end

  // the prescaler never passes its limit while running (R2)
  assert_presc_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pcnt <= plim));

endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_tick,
  input  logic          tx_en,
  input  logic          cts_en,
  input  logic          cts_n,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_data,
  output logic          txd,
  output logic          sclk,
  output logic          buf_empty,
  output logic          tx_idle,
  output logic          load_evt,
  output logic          char_end_evt
);
  import sstx_pkg::*;

  localparam int HALVES = 2 * DW;
  localparam int HW     = $clog2(HALVES);

  tx_state_e     state;
  logic [DW-1:0] buf_q;
  logic          buf_full;
  logic [DW-1:0] sreg;
  logic [HW-1:0] hcnt;
  logic          may_start;
  logic          last_half;

  assign may_start    = buf_full && tx_en && (!cts_en || !cts_n);
  assign last_half    = (state == ST_SHIFT) && half_tick && (hcnt == HW'(HALVES - 1));
  assign load_evt     = may_start && ((state == ST_IDLE) || last_half);
  assign char_end_evt = last_half;
  assign buf_empty    = !buf_full;
  assign tx_idle      = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
    end else begin
      buf_full <= (buf_full && !load_evt) || buf_wr;
      if (buf_wr) buf_q <= buf_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sreg  <= '0;
      hcnt  <= '0;
      sclk  <= 1'b1;
      txd   <= 1'b1;
    end else if (load_evt) begin
      state <= ST_SHIFT;
      sreg  <= buf_q;
      hcnt  <= '0;
      sclk  <= 1'b0;
      txd   <= buf_q[0];
    end else if (last_half) begin
      state <= ST_IDLE;
      sclk  <= 1'b1;
      txd   <= 1'b1;
    end else if ((state == ST_SHIFT) && half_tick) begin
      hcnt <= hcnt + 1'b1;
      if (!hcnt[0]) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        sreg <= {1'b0, sreg[DW-1:1]};
        txd  <= sreg[1];
      end
    end
  end

  // a transfer can only happen from a full buffer (R4)
  assert_load_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> buf_empty || $past(buf_wr));

endmodule

// File: rtl/sstx_irq.sv
module sstx_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_sel,
  input  logic load_evt,
  input  logic char_end_evt,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_sel ? char_end_evt : load_evt;
  end

  // interrupt is a single-cycle pulse (R8)
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DW       = 8,
  parameter int MW       = 8,
  parameter int NW       = 8,
  parameter int SLOW_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    src_sel,
  input  logic [NW-1:0] pre_n,
  input  logic [MW-1:0] baud_m,
  input  logic          tx_en,
  input  logic          cts_en,
  input  logic          cts_n,
  input  logic          irq_sel,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_data,
  output logic          txd,
  output logic          sclk,
  output logic          buf_empty,
  output logic          tx_idle,
  output logic          irq
);
  logic half_tick;
  logic load_evt;
  logic char_end_evt;

  sstx_clkgen #(.MW(MW), .NW(NW), .SLOW_DIV(SLOW_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(!tx_idle),
    .src_sel(src_sel), .pre_n(pre_n), .baud_m(baud_m),
    .half_tick(half_tick)
  );

  sstx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .tx_en(tx_en), .cts_en(cts_en), .cts_n(cts_n),
    .buf_wr(buf_wr), .buf_data(buf_data),
    .txd(txd), .sclk(sclk), .buf_empty(buf_empty), .tx_idle(tx_idle),
    .load_evt(load_evt), .char_end_evt(char_end_evt)
  );

  sstx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .irq_sel(irq_sel),
    .load_evt(load_evt), .char_end_evt(char_end_evt), .irq(irq)
  );

  // shift clock moves only on a divider half tick or a transfer (R2)
  assert_sclk_paced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(half_tick || load_evt));

  // data changes only while the clock is low or the line is idle (R3)
  assert_txd_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> (!sclk || tx_idle));

  // buffer frees only by starting a character (R4)
  assert_empty_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> !tx_idle);

  // no start while clear-to-send is deasserted (R6)
  assert_cts_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_idle) |-> $past(!cts_en || !cts_n));

  // no start while disabled (R7)
  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_idle) |-> $past(tx_en));

  // idle line holds clock and data high (R9)
  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (sclk && txd));

endmodule

// File: tb/sync_ser_tx_test.sv
module sync_ser_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [7:0] pre_n = 8'd0;
  logic [7:0] baud_m = 8'd1;
  logic       tx_en = 1'b1;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       irq_sel = 1'b0;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_data = 8'h00;
  logic       txd, sclk, buf_empty, tx_idle, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sync_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pre_n(pre_n), .baud_m(baud_m),
    .tx_en(tx_en), .cts_en(cts_en), .cts_n(cts_n), .irq_sel(irq_sel),
    .buf_wr(buf_wr), .buf_data(buf_data),
    .txd(txd), .sclk(sclk), .buf_empty(buf_empty), .tx_idle(tx_idle), .irq(irq)
  );

  // {src_sel, pre_n, baud_m, data}
  localparam logic [25:0] VEC [6] = '{
    {2'd0, 8'd0, 8'd0, 8'hA5},
    {2'd0, 8'd0, 8'd3, 8'h3C},
    {2'd1, 8'd0, 8'd1, 8'h81},
    {2'd2, 8'd3, 8'd0, 8'h5A},
    {2'd2, 8'd0, 8'd2, 8'hFE},
    {2'd3, 8'd5, 8'd1, 8'h01}
  };

  function automatic int exp_half(input logic [1:0] s, input int n, input int m);
    int p;
    if (s == 2'd0)      p = 1;
    else if (s == 2'd1) p = 8;
    else                p = (n == 0) ? 2 : 2 * n;
    return p * (m + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); buf_wr = 1'b1; buf_data = d;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic wait_start();
    int c = 0;
    while (tx_idle && c < 4000) begin @(negedge clk); c++; end
  endtask

  // entered at the first negedge after a transfer; ends at the negedge where idle returns
  task automatic capture(input int nch, input int h, output logic [15:0] bits, output int bad);
    logic prev;
    int cnt;
    int idx = 0;
    bad = 0; bits = '0; prev = sclk;
    for (int t = 0; t < 16 * nch - 1; t++) begin
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (sclk == prev && cnt < 4000);
      if (cnt != h || tx_idle) bad++;
      prev = sclk;
      if (sclk) begin bits[idx] = txd; idx++; end
    end
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!tx_idle && cnt < 4000);
    if (cnt != h || !txd) bad++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] bits;
    int bad, h;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(buf_empty && tx_idle && sclk && txd && !irq, "R1 reset",
        {buf_empty, tx_idle, sclk, txd, irq}, 5'b11110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(buf_empty && tx_idle && sclk && txd && !irq, "R1 after release",
        {buf_empty, tx_idle, sclk, txd, irq}, 5'b11110);

    // vector table: R2 timing, R3 order, R4 transfer, R8 select 0, R9 idle
    foreach (VEC[i]) begin
      src_sel = VEC[i][25:24]; pre_n = VEC[i][23:16]; baud_m = VEC[i][15:8];
      irq_sel = 1'b0;
      h = exp_half(VEC[i][25:24], int'(VEC[i][23:16]), int'(VEC[i][15:8]));
      wr(VEC[i][7:0]);
      @(negedge clk);
      chk(!tx_idle && buf_empty && !sclk, "R4 transfer edge",
          {tx_idle, buf_empty, sclk}, 3'b010);
      chk(irq, "R8 irq on transfer", irq, 1);
      capture(1, h, bits, bad);
      chk(bad == 0, "R2 half period", bad, 0);
      chk(bits[7:0] == VEC[i][7:0], "R3 bit order", bits[7:0], VEC[i][7:0]);
      chk(!irq, "R8 no end irq with select 0", irq, 0);
      repeat (3) @(negedge clk);
    end

    src_sel = 2'd0; baud_m = 8'd1; h = 2;

    // R7 enable gating
    tx_en = 1'b0;
    wr(8'hC3);
    chk(!buf_empty, "R4 write clears empty", buf_empty, 0);
    repeat (30) @(negedge clk);
    chk(tx_idle && sclk && !buf_empty, "R7 held while disabled",
        {tx_idle, sclk, buf_empty}, 3'b110);
    tx_en = 1'b1;
    @(negedge clk);
    chk(!tx_idle, "R7 start after enable", tx_idle, 0);
    capture(1, h, bits, bad);
    chk(bad == 0 && bits[7:0] == 8'hC3, "R7 char after enable", bits[7:0], 8'hC3);

    // R6 clear-to-send gating
    cts_en = 1'b1; cts_n = 1'b1;
    wr(8'h96);
    repeat (30) @(negedge clk);
    chk(tx_idle && sclk && !buf_empty, "R6 held by cts",
        {tx_idle, sclk, buf_empty}, 3'b110);
    cts_n = 1'b0;
    @(negedge clk);
    chk(!tx_idle && buf_empty, "R6 start on cts low", {tx_idle, buf_empty}, 2'b01);
    capture(1, h, bits, bad);
    chk(bad == 0 && bits[7:0] == 8'h96, "R6 char after cts", bits[7:0], 8'h96);
    cts_en = 1'b0; cts_n = 1'b1;
    wr(8'h4B);
    @(negedge clk);
    chk(!tx_idle, "R6 cts ignored when disabled", tx_idle, 0);
    capture(1, h, bits, bad);
    chk(bad == 0 && bits[7:0] == 8'h4B, "R6 char with cts ignored", bits[7:0], 8'h4B);
    cts_n = 1'b0;

    // R5 back-to-back with no gap, R8 select 1
    irq_sel = 1'b1;
    wr(8'h12);
    @(negedge clk);
    chk(!irq, "R8 no transfer irq with select 1", irq, 0);
    fork
      capture(2, h, bits, bad);
      begin
        @(negedge clk); buf_wr = 1'b1; buf_data = 8'hE7;
        @(negedge clk); buf_wr = 1'b0;
      end
    join
    chk(bad == 0, "R5 no gap between characters", bad, 0);
    chk(bits == 16'hE712, "R5 two characters", bits, 16'hE712);
    chk(irq, "R8 irq at character end", irq, 1);
    @(negedge clk);
    chk(!irq, "R8 irq single cycle", irq, 0);

    // R7 clear enable mid-character
    irq_sel = 1'b0;
    wr(8'h69);
    @(negedge clk);
    fork
      capture(1, h, bits, bad);
      begin
        @(negedge clk); buf_wr = 1'b1; buf_data = 8'h0F;
        @(negedge clk); buf_wr = 1'b0; tx_en = 1'b0;
      end
    join
    chk(bad == 0 && bits[7:0] == 8'h69, "R7 current char finishes", bits[7:0], 8'h69);
    repeat (40) @(negedge clk);
    chk(tx_idle && sclk && !buf_empty, "R9 stays idle after disable",
        {tx_idle, sclk, buf_empty}, 3'b110);
    tx_en = 1'b1;
    wait_start();
    capture(1, h, bits, bad);
    chk(bad == 0 && bits[7:0] == 8'h0F, "R7 waiting byte sent", bits[7:0], 8'h0F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule